// File: doc/BRIEF.md
# Serial Controller Register and Interrupt Unit

This block is the host-side register file of a byte-oriented serial controller. It sits on a simple byte bus with a 4-bit offset, a read strobe and a write strobe. It turns host accesses into configuration and strobes for the transmit path, the receive path and the modem-line logic, and it collects their status. Several offsets reach different storage depending on the direction of the access. The divisor bytes share offsets 0 and 1 with the data and enable registers, and a control bit in the line-control register selects between them.

Pending interrupt causes are ranked and presented as a small identification code. A single interrupt line follows that code. Reading the identification or modem-status register, or writing the transmit holding register, acknowledges the matching cause. Read data is combinational from the current state. Side effects of a read, such as a pop request or clearing a cause, take place at the clock edge that ends the read cycle.

Top module: `uart_regfile`

## Requirements
- R1: After reset, offset 2 reads 0x01, `irq` is low, and the enable, line-control, modem-control, scratch, mode and divisor registers are all zero.
- R2: With line-control bit 7 clear, a read of offset 0 returns `rxData` and pulses `rxPop`, and a write of offset 0 pulses `txLoad` with `txData` equal to the written byte. With bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes. In that case `rxPop` and `txLoad` stay low.
- R3: Offset 1 (bit 7 clear) holds a 4-bit interrupt enable: bit0 received data, bit1 transmit empty, bit2 line status, bit3 modem status. Bits 7:4 read as 0.
- R4: Offset 2 reads {fifoEn, fifoEn, 2'b00, code}. The code is 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit empty, 0x0 for modem status and 0x1 for nothing pending. Only enabled causes count, and the highest-ranked one is shown, in the order just listed.
- R5: Received data and timeout share one rank. When both are pending, the code is 0x4. Timeout alone gives 0xC.
- R6: A write of offset 2 pulses `fifoCtlWr` with `fifoCtl` equal to the written byte. Written bit0 becomes `fifoEn`, and identification bits 7:6 then read 11.
- R7: The transmit-empty cause is set when `thrEmpty` rises, or when enable bit1 is written from 0 to 1 while `thrEmpty` is high. It is cleared by an offset-0 data write, or by an offset-2 read while the code shows 0x2. A read showing another code leaves it set.
- R8: Offset 6 reads the levels of DCD, RI, DSR, CTS in bits 7:4, and change flags in bits 3:0. Bit0 is a CTS change, bit1 a DSR change, bit2 a falling RI, and bit3 a DCD change. A read clears the flags. A change in the same cycle as the read is kept.
- R9: Modem-control bit0 drives `dtrOut` and bit1 drives `rtsOut`, and bit4 selects loopback. In loopback both outputs are low, and the modem levels come from the modem-control register: CTS from bit1, DSR from bit0, RI from bit2 and DCD from bit3.
- R10: Offset 7 is an 8-bit scratch register and offset 8 an 8-bit mode register whose bits 2:0 drive `modeSel` (0 selects plain serial mode). Offsets 9 to 15 read 0 and ignore writes.
- R11: `irq` is high exactly when identification bit0 is 0.
- R12: Offset 3 reads back the line-control byte, which is also driven on `lineCtl`. Offset 5 returns `lineStat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| rxData | input | 8 | Byte at the head of the receive path |
| rxAvail | input | 1 | Receive data cause from the receive path |
| rxTimeout | input | 1 | Character timeout cause from the receive path |
| lineIrq | input | 1 | Receive line-error cause |
| lineStat | input | 8 | Line status byte from transmit and receive paths |
| thrEmpty | input | 1 | Transmit holding register empty |
| ctsIn | input | 1 | Clear-to-send level |
| dsrIn | input | 1 | Data-set-ready level |
| riIn | input | 1 | Ring indicator level |
| dcdIn | input | 1 | Carrier detect level |
| txData | output | 8 | Byte for the transmit path |
| txLoad | output | 1 | Transmit byte load pulse |
| rxPop | output | 1 | Receive byte consumed pulse |
| fifoCtl | output | 8 | FIFO control byte |
| fifoCtlWr | output | 1 | FIFO control write pulse |
| fifoEn | output | 1 | FIFOs enabled |
| divisor | output | 16 | Baud divisor {high, low} |
| lineCtl | output | 8 | Line-control byte |
| dtrOut | output | 1 | Terminal-ready output |
| rtsOut | output | 1 | Request-to-send output |
| loopback | output | 1 | Internal loopback selected |
| modeSel | output | 3 | Operating mode select |

## Verification
The ranking logic is driven with every pending cause alone, with pairs and with all causes together, with enables both set and cleared. This separates a wrong rank order from a missing enable gate. The shared offsets are accessed with the divisor-select bit both set and clear, and a data access that leaks through the divisor window shows up as a stray pop or load pulse. The acknowledge paths are tried in several conditions: an identification read showing transmit empty, one showing a different code, and a modem-line change that lands in the same cycle as a status read. Each of these gives a different code or flag byte. A long random mix of accesses and input toggles, including loopback switching, is then followed clock by clock by a behavioural model.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIV_W   = 2 * BYTE_W;
  localparam int IER_W   = 4;
  localparam int MCR_W   = 5;
  localparam int MODE_W  = 3;
  localparam int LEV_W   = 4;
  localparam int DLAB_BIT = 7;
  localparam int LOOP_BIT = 4;
  localparam int RI_IDX   = 2;

  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_IIR  = 2;
  localparam int OFS_LCR  = 3;
  localparam int OFS_MCR  = 4;
  localparam int OFS_LSR  = 5;
  localparam int OFS_MSR  = 6;
  localparam int OFS_SCR  = 7;
  localparam int OFS_MODE = 8;

  localparam logic [3:0] CODE_NONE  = 4'h1;
  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_RXD   = 4'h4;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_THRE  = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_DLL, SEL_IER, SEL_DLM, SEL_IIR, SEL_LCR,
    SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR, SEL_MODE, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic wrThr;
    logic wrDll;
    logic wrDlm;
    logic wrIer;
    logic wrFcr;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic wrMode;
    logic rdRbr;
    logic rdIir;
    logic rdMsr;
  } regStb_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  output regStb_t           stb,
  output regSel_e           rdSel
);
  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    case (addr)
      ADDR_W'(OFS_DATA): begin
        rdSel     = dlab ? SEL_DLL : SEL_RBR;
        stb.wrDll = wrEn & dlab;
        stb.wrThr = wrEn & ~dlab;
        stb.rdRbr = rdEn & ~dlab;
      end
      ADDR_W'(OFS_IER): begin
        rdSel     = dlab ? SEL_DLM : SEL_IER;
        stb.wrDlm = wrEn & dlab;
        stb.wrIer = wrEn & ~dlab;
      end
      ADDR_W'(OFS_IIR): begin
        rdSel     = SEL_IIR;
        stb.wrFcr = wrEn;
        stb.rdIir = rdEn;
      end
      ADDR_W'(OFS_LCR): begin
        rdSel     = SEL_LCR;
        stb.wrLcr = wrEn;
      end
      ADDR_W'(OFS_MCR): begin
        rdSel     = SEL_MCR;
        stb.wrMcr = wrEn;
      end
      ADDR_W'(OFS_LSR): rdSel = SEL_LSR;
      ADDR_W'(OFS_MSR): begin
        rdSel     = SEL_MSR;
        stb.rdMsr = rdEn;
      end
      ADDR_W'(OFS_SCR): begin
        rdSel     = SEL_SCR;
        stb.wrScr = wrEn;
      end
      ADDR_W'(OFS_MODE): begin
        rdSel      = SEL_MODE;
        stb.wrMode = wrEn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_reg_dp.sv
module uart_reg_dp
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  regStb_t           stb,
  input  regSel_e           rdSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxAvail,
  input  logic              rxTimeout,
  input  logic              lineIrq,
  input  logic [BYTE_W-1:0] lineStat,
  input  logic              thrEmpty,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq,
  output logic              dlab,
  output logic              fifoEn,
  output logic [DIV_W-1:0]  divisor,
  output logic [BYTE_W-1:0] lineCtl,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic              loopback,
  output logic [MODE_W-1:0] modeSel
);
  logic [BYTE_W-1:0] dllQ, dlmQ, lcrQ, scrQ, modeQ;
  logic [IER_W-1:0]  ierQ;
  logic [MCR_W-1:0]  mcrQ;
  logic              fifoEnQ, threQ, thrEmptyQ;
  logic [LEV_W-1:0]  levQ, levNow, deltaQ, deltaEvt;
  logic [3:0]        iirCode;
  logic [BYTE_W-1:0] iirByte, msrByte;
  logic              threSet, threClr;

  // live modem levels packed as {dcd, ri, dsr, cts}
  assign loopback = mcrQ[LOOP_BIT];
  assign levNow = loopback ? {mcrQ[3], mcrQ[2], mcrQ[0], mcrQ[1]}
                           : {dcdIn, riIn, dsrIn, ctsIn};

  for (genvar i = 0; i < LEV_W; i++) begin : g_delta
    if (i == RI_IDX) begin : g_fall
      assign deltaEvt[i] = levQ[i] & ~levNow[i];
    end else begin : g_any
      assign deltaEvt[i] = levQ[i] ^ levNow[i];
    end
  end

  always_comb begin
    if (ierQ[2] & lineIrq)       iirCode = CODE_LINE;
    else if (ierQ[0] & rxAvail)  iirCode = CODE_RXD;
    else if (ierQ[0] & rxTimeout) iirCode = CODE_TMO;
    else if (ierQ[1] & threQ)    iirCode = CODE_THRE;
    else if (ierQ[3] & |deltaQ)  iirCode = CODE_MODEM;
    else                         iirCode = CODE_NONE;
  end

  assign iirByte = {fifoEnQ, fifoEnQ, 2'b00, iirCode};
  assign msrByte = {levNow, deltaQ};
  assign irq     = ~iirByte[0];

  assign threSet = (thrEmpty & ~thrEmptyQ) |
                   (stb.wrIer & ~ierQ[1] & wrData[1] & thrEmpty);
  assign threClr = stb.wrThr | (stb.rdIir & (iirCode == CODE_THRE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dllQ <= '0; dlmQ <= '0; lcrQ <= '0; scrQ <= '0; modeQ <= '0;
      ierQ <= '0; mcrQ <= '0; fifoEnQ <= 1'b0; threQ <= 1'b0;
      thrEmptyQ <= 1'b1; levQ <= '0; deltaQ <= '0;
    end else begin
      if (stb.wrDll)  dllQ  <= wrData;
      if (stb.wrDlm)  dlmQ  <= wrData;
      if (stb.wrLcr)  lcrQ  <= wrData;
      if (stb.wrScr)  scrQ  <= wrData;
      if (stb.wrMode) modeQ <= wrData;
      if (stb.wrIer)  ierQ  <= wrData[IER_W-1:0];
      if (stb.wrMcr)  mcrQ  <= wrData[MCR_W-1:0];
      if (stb.wrFcr)  fifoEnQ <= wrData[0];
      if (threSet)      threQ <= 1'b1;
      else if (threClr) threQ <= 1'b0;
      thrEmptyQ <= thrEmpty;
      levQ      <= levNow;
      deltaQ    <= (stb.rdMsr ? '0 : deltaQ) | deltaEvt;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_RBR:  rdData = rxData;
      SEL_DLL:  rdData = dllQ;
      SEL_IER:  rdData = {{(BYTE_W-IER_W){1'b0}}, ierQ};
      SEL_DLM:  rdData = dlmQ;
      SEL_IIR:  rdData = iirByte;
      SEL_LCR:  rdData = lcrQ;
      SEL_MCR:  rdData = {{(BYTE_W-MCR_W){1'b0}}, mcrQ};
      SEL_LSR:  rdData = lineStat;
      SEL_MSR:  rdData = msrByte;
      SEL_SCR:  rdData = scrQ;
      SEL_MODE: rdData = modeQ;
      default:  rdData = '0;
    endcase
  end

  assign dlab    = lcrQ[DLAB_BIT];
  assign fifoEn  = fifoEnQ;
  assign divisor = {dlmQ, dllQ};
  assign lineCtl = lcrQ;
  assign dtrOut  = mcrQ[0] & ~loopback;
  assign rtsOut  = mcrQ[1] & ~loopback;
  assign modeSel = modeQ[MODE_W-1:0];
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq,
  input  logic [7:0]        rxData,
  input  logic              rxAvail,
  input  logic              rxTimeout,
  input  logic              lineIrq,
  input  logic [7:0]        lineStat,
  input  logic              thrEmpty,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn,
  output logic [7:0]        txData,
  output logic              txLoad,
  output logic              rxPop,
  output logic [7:0]        fifoCtl,
  output logic              fifoCtlWr,
  output logic              fifoEn,
  output logic [15:0]       divisor,
  output logic [7:0]        lineCtl,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic              loopback,
  output logic [2:0]        modeSel
);
  regStb_t stb;
  regSel_e rdSel;
  logic    dlab;

  uart_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .dlab(dlab),
    .stb(stb), .rdSel(rdSel)
  );

  uart_reg_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rdSel(rdSel), .wrData(wrData),
    .rxData(rxData), .rxAvail(rxAvail), .rxTimeout(rxTimeout),
    .lineIrq(lineIrq), .lineStat(lineStat), .thrEmpty(thrEmpty),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn),
    .rdData(rdData), .irq(irq), .dlab(dlab), .fifoEn(fifoEn),
    .divisor(divisor), .lineCtl(lineCtl), .dtrOut(dtrOut),
    .rtsOut(rtsOut), .loopback(loopback), .modeSel(modeSel)
  );

  assign txData    = wrData;
  assign txLoad    = stb.wrThr;
  assign rxPop     = stb.rdRbr;
  assign fifoCtl   = wrData;
  assign fifoCtlWr = stb.wrFcr;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              irq,
  input logic              txLoad,
  input logic              rxPop,
  input logic [15:0]       divisor,
  input logic [7:0]        lineCtl,
  input logic              dtrOut,
  input logic              rtsOut,
  input logic              loopback,
  input logic [2:0]        modeSel
);
  // R11
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == ADDR_W'(2)) |-> (rdData[0] == !irq));

  // R2
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(0) && !lineCtl[7]) |-> txLoad);

  // R2
  dlab_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineCtl[7] |-> (!txLoad && !rxPop));

  // R2
  div_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(1) && lineCtl[7]) |=> (divisor[15:8] == $past(wrData)));

  // R9
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (!dtrOut && !rtsOut));

  // R10
  mode_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(8)) |=> (modeSel == $past(wrData[2:0])));

  // R12
  lcr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(3)) |=> (lineCtl == $past(wrData)));
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .irq(irq), .txLoad(txLoad),
  .rxPop(rxPop), .divisor(divisor), .lineCtl(lineCtl), .dtrOut(dtrOut),
  .rtsOut(rtsOut), .loopback(loopback), .modeSel(modeSel)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wrEn = 0, rdEn = 0;
  logic [7:0] wrData = '0, rdData, rxData = 8'h00, lineStat = 8'h60;
  logic rxAvail = 0, rxTimeout = 0, lineIrq = 0, thrEmpty = 1;
  logic ctsIn = 0, dsrIn = 0, riIn = 0, dcdIn = 0;
  logic irq, txLoad, rxPop, fifoCtlWr, fifoEn, dtrOut, rtsOut, loopback;
  logic [7:0] txData, fifoCtl, lineCtl;
  logic [15:0] divisor;
  logic [2:0] modeSel;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .rxData(rxData),
    .rxAvail(rxAvail), .rxTimeout(rxTimeout), .lineIrq(lineIrq),
    .lineStat(lineStat), .thrEmpty(thrEmpty), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .riIn(riIn), .dcdIn(dcdIn), .txData(txData), .txLoad(txLoad),
    .rxPop(rxPop), .fifoCtl(fifoCtl), .fifoCtlWr(fifoCtlWr), .fifoEn(fifoEn),
    .divisor(divisor), .lineCtl(lineCtl), .dtrOut(dtrOut), .rtsOut(rtsOut),
    .loopback(loopback), .modeSel(modeSel)
  );

  integer total = 0, bad = 0;
  logic [7:0] lastRd;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  logic [7:0] mIer, mLcr, mMcr, mScr, mMode, mDll, mDlm;
  logic mFifo, mThre, mPrevThr;
  logic [3:0] mPrev, mDelta;

  function automatic logic [3:0] mLev();
    if (mMcr[4]) return {mMcr[3], mMcr[2], mMcr[0], mMcr[1]};
    return {dcdIn, riIn, dsrIn, ctsIn};
  endfunction

  function automatic logic [3:0] mCode();
    if (mIer[2] && lineIrq) return 4'h6;
    if (mIer[0] && rxAvail) return 4'h4;
    if (mIer[0] && rxTimeout) return 4'hC;
    if (mIer[1] && mThre) return 4'h2;
    if (mIer[3] && mDelta != 0) return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] mRead(input int a);
    case (a)
      0: return mLcr[7] ? mDll : rxData;
      1: return mLcr[7] ? mDlm : {4'h0, mIer[3:0]};
      2: return {mFifo, mFifo, 2'b00, mCode()};
      3: return mLcr;
      4: return {3'b000, mMcr[4:0]};
      5: return lineStat;
      6: return {mLev(), mDelta};
      7: return mScr;
      8: return mMode;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 5: return "R12";
      4: return "R9";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mIer = 0; mLcr = 0; mMcr = 0; mScr = 0; mMode = 0; mDll = 0; mDlm = 0;
      mFifo = 0; mThre = 0; mPrevThr = 1; mPrev = 0; mDelta = 0;
    end else begin
      logic [3:0] code, lev, d;
      logic dl, wThr, setT, clrT;
      code = mCode(); lev = mLev(); dl = mLcr[7];
      wThr = wrEn && addr == 0 && !dl;
      setT = (thrEmpty && !mPrevThr) ||
             (wrEn && addr == 1 && !dl && !mIer[1] && wrData[1] && thrEmpty);
      clrT = wThr || (rdEn && addr == 2 && code == 4'h2);
      if (setT) mThre = 1; else if (clrT) mThre = 0;
      d = (rdEn && addr == 6) ? 4'h0 : mDelta;
      d[0] = d[0] | (lev[0] ^ mPrev[0]);
      d[1] = d[1] | (lev[1] ^ mPrev[1]);
      d[2] = d[2] | (mPrev[2] & !lev[2]);
      d[3] = d[3] | (lev[3] ^ mPrev[3]);
      mDelta = d; mPrev = lev; mPrevThr = thrEmpty;
      if (wrEn) begin
        case (addr)
          0: if (dl) mDll = wrData;
          1: if (dl) mDlm = wrData; else mIer = {4'h0, wrData[3:0]};
          2: mFifo = wrData[0];
          3: mLcr = wrData;
          4: mMcr = {3'b000, wrData[4:0]};
          7: mScr = wrData;
          8: mMode = wrData;
          default: ;
        endcase
      end
    end
  end

  // clock-by-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R11 irq", {15'b0, irq}, {15'b0, (mCode() != 4'h1)});
      check("R2 txLoad", {15'b0, txLoad}, {15'b0, wrEn && addr == 0 && !mLcr[7]});
      check("R2 rxPop", {15'b0, rxPop}, {15'b0, rdEn && addr == 0 && !mLcr[7]});
      check("R6 fifoCtlWr", {15'b0, fifoCtlWr}, {15'b0, wrEn && addr == 2});
      check("R6 fifoEn", {15'b0, fifoEn}, {15'b0, mFifo});
      check("R2 divisor", divisor, {mDlm, mDll});
      check("R12 lineCtl", {8'h0, lineCtl}, {8'h0, mLcr});
      check("R9 pins", {13'b0, loopback, dtrOut, rtsOut},
            {13'b0, mMcr[4], mMcr[0] && !mMcr[4], mMcr[1] && !mMcr[4]});
      check("R10 modeSel", {13'b0, modeSel}, {13'b0, mMode[2:0]});
      if (txLoad) check("R2 txData", {8'h0, txData}, {8'h0, wrData});
      if (fifoCtlWr) check("R6 fifoCtl", {8'h0, fifoCtl}, {8'h0, wrData});
      if (rdEn) check(tagOf(addr), {8'h0, rdData}, {8'h0, mRead(addr)});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    addr = a; rdEn = 1;
    @(negedge clk); lastRd = rdData;
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic rdExp(input string tag, input logic [3:0] a, input logic [7:0] e);
    rd(a);
    check(tag, {8'h0, lastRd}, {8'h0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1; tick(1);
    // R1 reset state
    rdExp("R1 iir", 2, 8'h01);
    check("R1 irq", {15'b0, irq}, 16'h0);
    rdExp("R1 lcr", 3, 8'h00);
    rdExp("R1 mcr", 4, 8'h00);
    rdExp("R1 ier", 1, 8'h00);
    check("R1 divisor", divisor, 16'h0000);
    // R2 divisor window and data path
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
    check("R2 divisor", divisor, 16'h1234);
    rdExp("R2 dll", 0, 8'h34);
    rdExp("R2 dlm", 1, 8'h12);
    wr(3, 8'h03);
    rxData = 8'hA5;
    rdExp("R2 rbr", 0, 8'hA5);
    wr(0, 8'h5A);
    // R3 enable width, R7 enable-edge arming
    wr(1, 8'hFF);
    rdExp("R3 ier", 1, 8'h0F);
    rdExp("R7 thre armed", 2, 8'h02);
    rdExp("R7 thre cleared", 2, 8'h01);
    // R4 / R5 ranking
    lineIrq = 1; rxAvail = 1; rxTimeout = 1; tick(1);
    rdExp("R4 line first", 2, 8'h06);
    lineIrq = 0; tick(1);
    rdExp("R5 rxd over timeout", 2, 8'h04);
    rxAvail = 0; tick(1);
    rdExp("R5 timeout", 2, 8'h0C);
    rxTimeout = 0; tick(1);
    rdExp("R4 idle", 2, 8'h01);
    // R7 rising edge, then modem below it
    thrEmpty = 0; tick(1); thrEmpty = 1; ctsIn = 1; tick(2);
    rdExp("R4 thre over modem", 2, 8'h02);
    rdExp("R4 modem", 2, 8'h00);
    rdExp("R8 cts delta", 6, 8'h11);
    rdExp("R8 cleared", 6, 8'h10);
    rdExp("R11 idle", 2, 8'h01);
    // R7 cleared by data write; kept through another code's read
    thrEmpty = 0; tick(1); thrEmpty = 1; tick(2);
    wr(0, 8'h11);
    rdExp("R7 write clears", 2, 8'h01);
    thrEmpty = 0; tick(1); thrEmpty = 1; rxAvail = 1; tick(2);
    rdExp("R7 other code", 2, 8'h04);
    rxAvail = 0; tick(1);
    rdExp("R7 still pending", 2, 8'h02);
    // R8 ring trailing edge and same-cycle change
    riIn = 1; tick(2);
    rdExp("R8 ri rise", 6, 8'h50);
    riIn = 0; tick(2);
    rdExp("R8 ri fall", 6, 8'h14);
    dsrIn = 1;
    rdExp("R8 read during change", 6, 8'h30);
    rdExp("R8 change kept", 6, 8'h32);
    // R6 FIFO control
    wr(2, 8'hC7);
    rdExp("R6 iir fifo", 2, 8'hC1);
    wr(2, 8'h00);
    rdExp("R6 fifo off", 2, 8'h01);
    // R9 modem control and loopback
    wr(4, 8'h03);
    check("R9 dtr rts", {14'b0, dtrOut, rtsOut}, 16'h0003);
    wr(4, 8'h1F); tick(1);
    check("R9 loop pins", {14'b0, dtrOut, rtsOut}, 16'h0000);
    rdExp("R9 loop levels", 6, 8'hF8);
    wr(4, 8'h10); tick(1);
    rdExp("R9 loop drop", 6, 8'h0F);
    wr(4, 8'h00); tick(1);
    // R10 scratch, mode, unused
    wr(7, 8'h9C);
    rdExp("R10 scratch", 7, 8'h9C);
    wr(8, 8'hFD);
    check("R10 modeSel", {13'b0, modeSel}, 16'h0005);
    rdExp("R10 mode", 8, 8'hFD);
    wr(9, 8'hFF);
    rdExp("R10 unused", 9, 8'h00);
    rdExp("R10 unused top", 15, 8'h00);
    rdExp("R12 lsr", 5, 8'h60);
    // random mix, followed by the model every clock
    for (int i = 0; i < 4000; i++) begin
      addr = 4'($urandom_range(0, 9));
      wrData = 8'($urandom);
      wrEn = ($urandom_range(0, 3) == 0);
      rdEn = ($urandom_range(0, 2) == 0);
      rxData = 8'($urandom); lineStat = 8'($urandom);
      rxAvail = ($urandom_range(0, 3) == 0);
      rxTimeout = ($urandom_range(0, 5) == 0);
      lineIrq = ($urandom_range(0, 7) == 0);
      thrEmpty = ($urandom_range(0, 2) != 0);
      ctsIn = ($urandom_range(0, 6) == 0) ? !ctsIn : ctsIn;
      dsrIn = ($urandom_range(0, 6) == 0) ? !dsrIn : dsrIn;
      riIn  = ($urandom_range(0, 6) == 0) ? !riIn : riIn;
      dcdIn = ($urandom_range(0, 6) == 0) ? !dcdIn : dcdIn;
      tick(1);
    end
    wrEn = 0; rdEn = 0; tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule